// File: doc/BRIEF.md
# Synthesizer Serial Configuration Register and Test Selector

This block is the control front end of a frequency synthesizer. It accepts a 14-bit configuration word over a three-wire serial path, made up of a data line, a serial clock and a load strobe. It also accepts divider values on parallel pins together with a parallel-load control. The word carries a 3-bit test-select code, a 2-bit output divider code N and a 9-bit feedback divider value M. A rising strobe copies the shifted word into holding registers. The registered select code then steers one of several internal signals onto a single test pin.

The PLL, the VCO and the output drivers live outside this block. The reference clock, the M counter output and the synthesizer output arrive as ordinary inputs. Every input is sampled on the block's system clock, so an edge on the serial clock or on the strobe takes effect at the first system clock edge that sees it high. While parallel load is active, M and N follow the parallel pins and the test-select register is held at zero. In that state the test pin shows the oldest bit of the shift register, which is the first bit shifted in.

Top module: `synth_cfg_ctrl`

## Requirements
- R1: Each rising serial clock shifts `ser_dat` into the low end of a 14-bit register. After 14 shifts the first bit sits at bit 13 and the last at bit 0, and the word reads {T[2:0], N[1:0], M[8:0]} from bit 13 down.
- R2: On the system clock edge that first samples `ser_ld` high, with `par_ld` low, `t_out`, `n_out` and `m_out` all take the shift register's fields together.
- R3: When neither strobe acts, `t_out`, `n_out` and `m_out` hold their values, including while serial bits are being shifted.
- R4: While `par_ld` is high, each clock edge loads `m_out` from `par_m` and `n_out` from `par_n`, and clears `t_out` to 000.
- R5: When `par_ld` and a serial strobe edge arrive in the same cycle, the parallel values win and `t_out` becomes 000.
- R6: With select 000, `test_out` shows bit 13 of the shift register. The value is registered and follows one clock later.
- R7: Select 001 drives `test_out` to a steady 1, and select 101 drives it to a steady 0.
- R8: Each selection below is registered with a one-clock delay on `test_out`. Select 010 passes `ref_clk_in`. Selects 011 and 110 pass `mcnt_in`. Select 100 passes `synth_in`.
- R9: Select 111 drives `test_out` with bit 1 of a counter of the rising edges of `synth_in` since reset, which divides `synth_in` by four.
- R10: `bypass` is high exactly when `t_out` is 110.
- R11: After reset, `m_out`, `n_out`, `t_out`, `bypass` and `test_out` are all 0, and the shift register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock; its rising edge is detected on clk |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe; its rising edge is detected on clk |
| par_ld | input | 1 | Parallel load, active high |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N value |
| ref_clk_in | input | 1 | Reference clock to observe |
| mcnt_in | input | 1 | M counter output to observe |
| synth_in | input | 1 | Synthesizer output to observe |
| m_out | output | 9 | Held M divider value |
| n_out | output | 2 | Held N divider code |
| t_out | output | 3 | Held test-select code |
| bypass | output | 1 | High when the bypass select is held |
| test_out | output | 1 | Test pin |

## Verification
The bench loads words whose single set bit sits at either end. A design that reversed the shift direction, or that split the fields at the wrong bit, would put T, N and M in the wrong places. It shifts a fresh word with no strobe, and it raises both loads in the same cycle. A design that leaked shifting into the held registers, or that let the serial strobe win, would corrupt the divider values. All eight select codes are swept against every pattern of the three observed inputs. This exposes a swapped mux entry, a missing bypass flag, or a divide-by-four that tracks levels rather than edges. After a parallel load, serial bits are clocked through one at a time. A design that did not clear the select, or that picked the wrong shift register bit, would show the wrong value on the test pin.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int TSEL_W = 3;

    typedef enum logic [TSEL_W-1:0] {
        SEL_SHIFT = 3'b000,
        SEL_HIGH  = 3'b001,
        SEL_REF   = 3'b010,
        SEL_MCNT  = 3'b011,
        SEL_SYN   = 3'b100,
        SEL_LOW   = 3'b101,
        SEL_BYP   = 3'b110,
        SEL_DIV4  = 3'b111
    } tsel_e;
endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int SW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_dat,
    input  logic          ser_ld,
    output logic [SW-1:0] sr,
    output logic          ld_pulse
);
    typedef struct packed {
        logic          sclk;
        logic          sld;
        logic [SW-1:0] word;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = ser_clk;
        st_d.sld  = ser_ld;
        if (ser_clk && !st_q.sclk) begin
            st_d.word = {st_q.word[SW-2:0], ser_dat};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr       = st_q.word;
    assign ld_pulse = ser_ld && !st_q.sld;
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch #(
    parameter int MW = 9,
    parameter int NW = 2,
    parameter int TW = 3,
    localparam int SW = MW + NW + TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_pulse,
    input  logic [SW-1:0] sr,
    input  logic          par_ld,
    input  logic [MW-1:0] par_m,
    input  logic [NW-1:0] par_n,
    output logic [MW-1:0] m,
    output logic [NW-1:0] n,
    output logic [TW-1:0] t
);
    typedef struct packed {
        logic [TW-1:0] t;
        logic [NW-1:0] n;
        logic [MW-1:0] m;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (par_ld) begin
            hold_d.m = par_m;
            hold_d.n = par_n;
            hold_d.t = '0;
        end else if (ld_pulse) begin
            hold_d = hold_t'(sr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign m = hold_q.m;
    assign n = hold_q.n;
    assign t = hold_q.t;
endmodule

// File: rtl/cfg_testmux.sv
module cfg_testmux
    import synth_cfg_pkg::*;
#(
    parameter int DIV_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TSEL_W-1:0] t,
    input  logic              sr_msb,
    input  logic              ref_clk_in,
    input  logic              mcnt_in,
    input  logic              synth_in,
    output logic              test_out,
    output logic              bypass
);
    typedef struct packed {
        logic                syn_prev;
        logic [DIV_LOG2-1:0] div;
        logic                pin;
    } mx_st_t;

    mx_st_t mx_d, mx_q;
    logic   sel_bit;

    always_comb begin
        unique case (tsel_e'(t))
            SEL_SHIFT: sel_bit = sr_msb;
            SEL_HIGH:  sel_bit = 1'b1;
            SEL_REF:   sel_bit = ref_clk_in;
            SEL_MCNT:  sel_bit = mcnt_in;
            SEL_SYN:   sel_bit = synth_in;
            SEL_LOW:   sel_bit = 1'b0;
            SEL_BYP:   sel_bit = mcnt_in;
            default:   sel_bit = mx_q.div[DIV_LOG2-1];
        endcase
    end

    always_comb begin
        mx_d          = mx_q;
        mx_d.syn_prev = synth_in;
        if (synth_in && !mx_q.syn_prev) mx_d.div = mx_q.div + 1'b1;
        mx_d.pin      = sel_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mx_q <= '0;
        else        mx_q <= mx_d;
    end

    assign test_out = mx_q.pin;
    assign bypass   = (tsel_e'(t) == SEL_BYP);
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
    import synth_cfg_pkg::*;
#(
    parameter int MW       = 9,
    parameter int NW       = 2,
    parameter int DIV_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_ld,
    input  logic              par_ld,
    input  logic [MW-1:0]     par_m,
    input  logic [NW-1:0]     par_n,
    input  logic              ref_clk_in,
    input  logic              mcnt_in,
    input  logic              synth_in,
    output logic [MW-1:0]     m_out,
    output logic [NW-1:0]     n_out,
    output logic [TSEL_W-1:0] t_out,
    output logic              bypass,
    output logic              test_out
);
    localparam int SW = MW + NW + TSEL_W;

    logic [SW-1:0] sr_w;
    logic          ld_w;

    cfg_shift #(.SW(SW)) shift_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .sr(sr_w), .ld_pulse(ld_w)
    );

    cfg_latch #(.MW(MW), .NW(NW), .TW(TSEL_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .ld_pulse(ld_w), .sr(sr_w),
        .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
        .m(m_out), .n(n_out), .t(t_out)
    );

    cfg_testmux #(.DIV_LOG2(DIV_LOG2)) mux_i (
        .clk(clk), .rst_n(rst_n), .t(t_out), .sr_msb(sr_w[SW-1]),
        .ref_clk_in(ref_clk_in), .mcnt_in(mcnt_in), .synth_in(synth_in),
        .test_out(test_out), .bypass(bypass)
    );
endmodule

module synth_cfg_chk #(
    parameter int MW = 9,
    parameter int NW = 2,
    localparam int SW = MW + NW + 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_ld,
    input logic          par_ld,
    input logic [MW-1:0] par_m,
    input logic [NW-1:0] par_n,
    input logic [SW-1:0] sr,
    input logic [MW-1:0] m_out,
    input logic [NW-1:0] n_out,
    input logic [2:0]    t_out,
    input logic          bypass,
    input logic          test_out
);
    logic ld_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) ld_prev <= 1'b0;
        else        ld_prev <= ser_ld;
    end

    // R4
    par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_ld |=> (m_out == $past(par_m) && n_out == $past(par_n) && t_out == 3'b000));

    // R2
    ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ld && !ld_prev && !par_ld) |=> ({t_out, n_out, m_out} == $past(sr)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_ld && !(ser_ld && !ld_prev)) |=> $stable({t_out, n_out, m_out}));

    // R7
    const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_out == 3'b001) |=> test_out);

    // R7
    const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_out == 3'b101) |=> !test_out);

    // R10
    bypass_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass) |-> (t_out == 3'b110));
endmodule

bind synth_cfg_ctrl synth_cfg_chk #(.MW(MW), .NW(NW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ser_ld(ser_ld), .par_ld(par_ld),
    .par_m(par_m), .par_n(par_n), .sr(sr_w), .m_out(m_out), .n_out(n_out),
    .t_out(t_out), .bypass(bypass), .test_out(test_out)
);

// File: tb/synth_cfg_ctrl_tb.sv
module synth_cfg_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ref_clk_in = 1'b0, mcnt_in = 1'b0, synth_in = 1'b0;
    logic [8:0] m_out;
    logic [1:0] n_out;
    logic [2:0] t_out;
    logic       bypass, test_out;

    int checks = 0, fails = 0, rises = 0;
    logic [13:0] exp_sr = '0;
    logic [13:0] exp_hold = '0;
    bit done = 0;

    always #10 clk = ~clk;

    synth_cfg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
        .ref_clk_in(ref_clk_in), .mcnt_in(mcnt_in), .synth_in(synth_in),
        .m_out(m_out), .n_out(n_out), .t_out(t_out), .bypass(bypass),
        .test_out(test_out)
    );

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        ser_dat = b;
        tick(2);
        ser_clk = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        exp_sr = {exp_sr[12:0], b};
    endtask

    task automatic shift_word(logic [13:0] w);
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe();
        ser_ld = 1'b1;
        tick(2);
        ser_ld = 1'b0;
        tick(1);
        exp_hold = exp_sr;
    endtask

    task automatic check_hold(string req);
        chk({t_out, n_out, m_out} == exp_hold, req, {t_out, n_out, m_out}, exp_hold);
    endtask

    task automatic set_src(logic r, logic mc, logic s);
        if (s && !synth_in) rises++;
        ref_clk_in = r;
        mcnt_in = mc;
        synth_in = s;
        tick(2);
    endtask

    function automatic logic exp_pin(logic [2:0] code, logic r, logic mc, logic s);
        case (code)
            3'b000: return exp_sr[13];
            3'b001: return 1'b1;
            3'b010: return r;
            3'b011: return mc;
            3'b100: return s;
            3'b101: return 1'b0;
            3'b110: return mc;
            default: return logic'((rises >> 1) & 1);
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [13:0] words [6];
        words[0] = 14'h2000; words[1] = 14'h0001; words[2] = 14'h3FFF;
        words[3] = 14'h2AAA; words[4] = 14'h1555; words[5] = 14'h0000;

        tick(3);
        // R11 reset state
        chk(m_out == 0 && n_out == 0 && t_out == 0, "R11", {t_out, n_out, m_out}, 0);
        chk(bypass == 0 && test_out == 0, "R11", {bypass, test_out}, 0);
        rst_n = 1'b1;
        tick(2);

        // R1 and R2: field layout and load on strobe
        foreach (words[i]) begin
            shift_word(words[i]);
            strobe();
            check_hold("R1_R2");
        end
        chk(t_out == 3'b000, "R1", t_out, 0);

        // R3: shift without strobe keeps the held values
        shift_word(14'h3A5C);
        tick(2);
        check_hold("R3");

        // R4: parallel load
        par_m = 9'h1A7; par_n = 2'b10; par_ld = 1'b1;
        tick(1);
        par_ld = 1'b0;
        tick(1);
        exp_hold = {3'b000, 2'b10, 9'h1A7};
        check_hold("R4");

        // R6: select 000 shows bit 13, which is the first bit of the last word
        tick(1);
        chk(test_out == 1'b1, "R6", test_out, 1);
        for (int i = 0; i < 14; i++) begin
            shift_bit(logic'((i * 5 + 1) % 3 == 0));
            tick(1);
            chk(test_out == exp_sr[13], "R6", test_out, exp_sr[13]);
        end

        // R5: parallel load wins over a simultaneous serial strobe
        shift_word(14'h3FFF);
        par_m = 9'h055; par_n = 2'b01;
        par_ld = 1'b1; ser_ld = 1'b1;
        tick(1);
        par_ld = 1'b0;
        tick(1);
        ser_ld = 1'b0;
        tick(1);
        exp_hold = {3'b000, 2'b01, 9'h055};
        check_hold("R5");

        // R7 R8 R9 R10: sweep every select code against every source pattern
        for (int c = 0; c < 8; c++) begin
            shift_word({c[2:0], 2'b11, 9'h0C3});
            strobe();
            check_hold("R2");
            chk(bypass == (c == 6), "R10", bypass, (c == 6));
            for (int p = 0; p < 8; p++) begin
                set_src(p[0], p[1], p[2]);
                chk(test_out == exp_pin(c[2:0], p[0], p[1], p[2]),
                    c == 7 ? "R9" : (c == 1 || c == 5) ? "R7" : c == 0 ? "R6" : "R8",
                    test_out, exp_pin(c[2:0], p[0], p[1], p[2]));
            end
            if (c == 7) begin
                for (int k = 0; k < 10; k++) begin
                    set_src(1'b0, 1'b0, logic'(k % 2));
                    tick(1);
                    chk(test_out == exp_pin(3'b111, 0, 0, 0), "R9",
                        test_out, exp_pin(3'b111, 0, 0, 0));
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule